// File: doc/BRIEF.md
# Maximum-Length Sequence Counter

This block is a shift-register counter with linear feedback. Each enabled clock moves every stage one place towards the top, and the bottom stage takes the exclusive-OR of a fixed set of tapped stages. The taps are chosen per width so that, from any nonzero start, the register walks through every nonzero value before it repeats. The block suits pseudo-random test patterns, cheap long-period timers and scramblers that need no carry chain.

A run-time mode input adds the all-zero value to the cycle, which lengthens the period to a full power of two. A load input writes an arbitrary seed. Synchronous reset restores a parameterized nonzero seed, which is all ones by default. The whole register and its top stage (as a serial bit) are outputs. The supported widths are 2, 3, 4, 5, 7, 12 and 16.

Top module: `lfsr_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes `RESET_SEED`, which is all ones by default. Reset takes priority over load and enable.
- R2: With `rst` and `load` low and `enable` low, the state holds its value.
- R3: On an enabled step (enable high, load low), bit i of the new state equals bit i-1 of the old state for i = 1..WIDTH-1, and `serial_out` always equals state bit WIDTH-1.
- R4: In normal mode the new bit 0 is the XOR of the tapped old bits. The tap bit positions are: width 2 {1,0}, width 3 {2,1}, width 4 {3,2}, width 5 {4,2}, width 7 {6,3}, width 12 {11,5,3,0}, width 16 {15,14,12,3}.
- R5: In normal mode (`full_period` = 0), starting from all ones, the first return to all ones happens after exactly 2^WIDTH-1 enabled steps, and the all-zero value never appears.
- R6: In normal mode the all-zero state is a lock-up: enabled steps leave it at zero.
- R7: In extended mode (`full_period` = 1), the value with only bit WIDTH-1 set steps to all zeros, and all zeros steps to the value 1. From all ones the first return takes exactly 2^WIDTH steps and visits zero.
- R8: When `load` is high (and `rst` low), the state becomes `seed` whatever `enable` is. Load overrides shifting, and a zero seed is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to `RESET_SEED` |
| enable | input | 1 | Advance one step per clock when high |
| full_period | input | 1 | 1 = include the all-zero value (period 2^WIDTH) |
| load | input | 1 | Write `seed` into the register |
| seed | input | WIDTH | Value written when `load` is high |
| state | output | WIDTH | Current register contents |
| serial_out | output | 1 | Top stage of the register |

## Verification
The bench runs all seven widths side by side and counts the steps to the first return to all ones, in both modes. A wrong tap shows up as a short period, and broken zero insertion shows up as a period that is one short or as a counter that sticks at zero. Directed vectors on a 4-bit instance go through the path 1000 → 0000 → 0001 in extended mode, the lock-up at zero in normal mode, a load with enable low and with enable high, and reset while load is high. A design with the wrong priority would keep the old state, shift the seed, or take the seed instead of the reset value.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  localparam int MAX_W = 16;

  // Feedback tap positions for each supported width (bit i set = stage i taps).
  function automatic logic [MAX_W-1:0] tap_mask(input int w);
    logic [MAX_W-1:0] m;
    case (w)
      2:       m = 16'h0003;
      3:       m = 16'h0006;
      4:       m = 16'h000C;
      5:       m = 16'h0014;
      7:       m = 16'h0048;
      12:      m = 16'h0829;
      16:      m = 16'hD008;
      default: m = MAX_W'(1) << (w - 1);
    endcase
    return m;
  endfunction

  // Linear period length in normal mode.
  function automatic longint period_normal(input int w);
    return (longint'(1) << w) - 1;
  endfunction

endpackage

// File: rtl/lfsr_feedback.sv
module lfsr_feedback #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             full_period,
  output logic             lin_bit,
  output logic             zero_tail,
  output logic             fb_bit
);
  localparam logic [lfsr_pkg::MAX_W-1:0] TAPS_ALL = lfsr_pkg::tap_mask(WIDTH);
  localparam logic [WIDTH-1:0]           TAPS     = TAPS_ALL[WIDTH-1:0];

  logic [WIDTH-1:0] tapped;

  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (TAPS[i]) begin : g_on
      assign tapped[i] = cur[i];
    end else begin : g_off
      assign tapped[i] = 1'b0;
    end
  end

  assign lin_bit   = ^tapped;
  assign zero_tail = ~|cur[WIDTH-2:0];
  assign fb_bit    = lin_bit ^ (full_period & zero_tail);
endmodule

// File: rtl/lfsr_shift_reg.sv
module lfsr_shift_reg #(
  parameter int               WIDTH      = 4,
  parameter logic [WIDTH-1:0] RESET_SEED = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  input  logic             step,
  input  logic             fb_in,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] shifted;

  assign shifted = {q[WIDTH-2:0], fb_in};

  always_ff @(posedge clk) begin
    if (rst)       q <= RESET_SEED;
    else if (load) q <= seed;
    else if (step) q <= shifted;
  end
endmodule

// File: rtl/lfsr_counter.sv
module lfsr_counter #(
  parameter int               WIDTH      = 4,
  parameter logic [WIDTH-1:0] RESET_SEED = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             full_period,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] state,
  output logic             serial_out
);
  logic do_step;
  logic lin_bit;
  logic zero_tail;
  logic fb_bit;

  assign do_step = enable & ~load;

  lfsr_feedback #(.WIDTH(WIDTH)) u_fb (
    .cur         (state),
    .full_period (full_period),
    .lin_bit     (lin_bit),
    .zero_tail   (zero_tail),
    .fb_bit      (fb_bit)
  );

  lfsr_shift_reg #(.WIDTH(WIDTH), .RESET_SEED(RESET_SEED)) u_sr (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .seed  (seed),
    .step  (do_step),
    .fb_in (fb_bit),
    .q     (state)
  );

  assign serial_out = state[WIDTH-1];
endmodule

// File: rtl/lfsr_counter_chk.sv
module lfsr_counter_chk #(
  parameter int               WIDTH      = 4,
  parameter logic [WIDTH-1:0] RESET_SEED = '1
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             full_period,
  input logic             load,
  input logic [WIDTH-1:0] seed,
  input logic [WIDTH-1:0] state,
  input logic             do_step
);
  localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  a_r1_reset_seed: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> state == RESET_SEED);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !enable) |=> $stable(state));

  a_r3_shift: assert property (@(posedge clk) disable iff (rst)
    do_step |=> state[WIDTH-1:1] == $past(state[WIDTH-2:0]));

  a_r5_no_zero: assert property (@(posedge clk) disable iff (rst)
    (!full_period && do_step && state != '0) |=> state != '0);

  a_r6_lockup: assert property (@(posedge clk) disable iff (rst)
    (!full_period && do_step && state == '0) |=> state == '0);

  a_r7_zero_entry: assert property (@(posedge clk) disable iff (rst)
    (full_period && do_step && state == TOP_ONLY) |=> state == '0);

  a_r7_zero_exit: assert property (@(posedge clk) disable iff (rst)
    (full_period && do_step && state == '0) |=> state == ONE);

  a_r8_load: assert property (@(posedge clk) disable iff (rst)
    load |=> state == $past(seed));
endmodule

bind lfsr_counter lfsr_counter_chk #(.WIDTH(WIDTH), .RESET_SEED(RESET_SEED)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .full_period (full_period),
  .load        (load),
  .seed        (seed),
  .state       (state),
  .do_step     (do_step)
);

// File: tb/lfsr_counter_test.sv
module lfsr_counter_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int errors = 0;

  // ---------------- 4-bit directed instance ----------------
  logic       rst = 1'b1, enable = 1'b0, full_period = 1'b0, load = 1'b0;
  logic [3:0] seed = 4'h0;
  logic [3:0] state;
  logic       serial_out;

  lfsr_counter #(.WIDTH(4)) uut (
    .clk(clk), .rst(rst), .enable(enable), .full_period(full_period),
    .load(load), .seed(seed), .state(state), .serial_out(serial_out)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       rst;
    logic       load;
    logic       en;
    logic       ext;
    logic [3:0] seed;
    logic [3:0] exp;
  } vec_t;

  // Width 4 taps bits 3 and 2: next = {q[2:0], q3^q2 (^ extra when ext and q[2:0]==0)}
  localparam vec_t VEC [16] = '{
    '{4'd1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 4'b1111},  // R1 reset
    '{4'd3, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 4'b1110},  // R3/R4
    '{4'd4, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 4'b1100},  // R4
    '{4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 4'b1100},  // R2 hold
    '{4'd4, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 4'b1000},  // R4
    '{4'd7, 1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 4'b0000},  // R7 into zero
    '{4'd7, 1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 4'b0001},  // R7 out of zero
    '{4'd7, 1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 4'b0010},  // R7
    '{4'd8, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 4'b0000},  // R8 zero seed
    '{4'd6, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 4'b0000},  // R6 lock-up
    '{4'd6, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 4'b0000},  // R6 lock-up
    '{4'd8, 1'b0, 1'b1, 1'b0, 1'b0, 4'h9, 4'b1001},  // R8 load, enable low
    '{4'd8, 1'b0, 1'b1, 1'b1, 1'b0, 4'h6, 4'b0110},  // R8 load beats shift
    '{4'd1, 1'b1, 1'b1, 1'b1, 1'b0, 4'h3, 4'b1111},  // R1 reset beats load
    '{4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 4'b1111},  // R2 hold
    '{4'd4, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 4'b1110}   // R4
  };

  task automatic check(input string tag, input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- period instances, all widths ----------------
  localparam int NW = 7;
  localparam int WL [NW] = '{2, 3, 4, 5, 7, 12, 16};

  logic p_rst = 1'b1, p_en = 1'b0, p_ext = 1'b0, meas = 1'b0;
  int   ret_all [NW];
  logic zs_all  [NW];

  for (genvar g = 0; g < NW; g++) begin : gw
    localparam int W = WL[g];
    logic [W-1:0] st;
    logic         so;
    int           cnt;
    int           ret;
    logic         zs;

    lfsr_counter #(.WIDTH(W)) u_w (
      .clk(clk), .rst(p_rst), .enable(p_en), .full_period(p_ext),
      .load(1'b0), .seed({W{1'b0}}), .state(st), .serial_out(so)
    );

    // Sample 2 ns after each edge; meas is the value present at that edge.
    always @(posedge clk) begin
      #2;
      if (!meas) begin
        cnt = 0; ret = 0; zs = 1'b0;
      end else begin
        cnt = cnt + 1;
        if (st == '0) zs = 1'b1;
        if (st == '1 && ret == 0) ret = cnt;
      end
    end

    assign ret_all[g] = ret;
    assign zs_all[g]  = zs;
  end

  // The step map is a bijection on its cycle, so a first return to the start
  // after exactly P steps also shows that no state repeated before.
  task automatic run_period(input logic ext, input int ncyc);
    @(negedge clk);
    p_rst = 1'b1; p_ext = ext; p_en = 1'b0; meas = 1'b0;
    @(negedge clk);
    @(negedge clk);
    p_rst = 1'b0; p_en = 1'b1; meas = 1'b1;
    repeat (ncyc) @(negedge clk);
    meas = 1'b0; p_en = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1", state, 4'b1111, "reset state");
    check("R3", serial_out, 1, "serial after reset");
    rst = 1'b0;

    for (int i = 0; i < 16; i++) begin
      rst = VEC[i].rst; load = VEC[i].load; enable = VEC[i].en;
      full_period = VEC[i].ext; seed = VEC[i].seed;
      @(negedge clk);
      check($sformatf("R%0d", VEC[i].req), state, VEC[i].exp, $sformatf("vector %0d state", i));
      check("R3", serial_out, VEC[i].exp[3], $sformatf("vector %0d serial", i));
    end
    rst = 1'b0; load = 1'b0; enable = 1'b0;

    // R5 / R4: normal-mode periods for every width
    run_period(1'b0, 65540);
    for (int g = 0; g < NW; g++) begin
      check("R5", ret_all[g], (64'd1 << WL[g]) - 1, $sformatf("normal period width %0d", WL[g]));
      check("R5", zs_all[g], 0, $sformatf("zero seen normal width %0d", WL[g]));
    end

    // R7: extended-mode periods (widths up to 12)
    run_period(1'b1, 4100);
    for (int g = 0; g < NW - 1; g++) begin
      check("R7", ret_all[g], 64'd1 << WL[g], $sformatf("extended period width %0d", WL[g]));
      check("R7", zs_all[g], 1, $sformatf("zero seen extended width %0d", WL[g]));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule